// File: doc/BRIEF.md
# Standby Wake and Interrupt Dispatch Gate

This block holds a small processor in a low-power standby state and releases it when a qualifying interrupt request appears. Release and interrupt entry are two separate decisions. Release depends only on request and enable flags. Interrupt entry also depends on the processor's current interrupt nesting level and its global interrupt enable. When the block decides to enter the handler, it does not raise the request at once. It first waits until two instructions have completed after release, and only then raises a dispatch request. That request stays up until the processor acknowledges it.

The maskable side has 64 request flags and 64 matching enable flags, organised as eight groups of eight. A non-maskable request line bypasses the enables. The nesting level is a 2-bit code:
- 0: no interrupt in service.
- 1: a maskable or software interrupt in service.
- 2: a non-maskable interrupt in service.
- 3: a debug-only interrupt in service.

Top module: `stb_wake_gate`

## Requirements
- R1: While reset is held and in the first cycle after its release, `standby`, `wake` and `disp_req` are all 0, and the block is in the running state.
- R2: In the running state with no dispatch deferred or pending, `sleep_req` sampled high at a clock edge sets `standby` to 1 from that edge.
- R3: While in standby, the block stays asleep when `nmi_req` is 0 and no bit position i has both `mreq[i]` and `men[i]` set. A request whose own enable is 0 never wakes it, even when other enables are set. This holds for every `nest_lvl` and `mie`.
- R4: Any single position i of the 64 with `mreq[i]` and `men[i]` both set wakes the block at the next edge. `wake` is then high for exactly one cycle, and `standby` falls in the same cycle that `wake` rises.
- R5: A set `nmi_req` always wakes the block. It leads to dispatch when `nest_lvl` is 0, 1 or 2, and to a plain resume when `nest_lvl` is 3.
- R6: An enabled maskable request with `mie` = 0 wakes the block without dispatch. With `mie` = 1 it leads to dispatch only when `nest_lvl` is 0 or 1. At levels 2 and 3 it wakes without dispatch.
- R7: When the non-maskable and maskable paths both qualify in the same cycle, the non-maskable decision (R5) decides dispatch.
- R8: After a wake that leads to dispatch, `disp_req` stays 0 until two `retire` strobes have been seen. Counting starts in the cycle that `wake` is high. `disp_req` rises at the clock edge that samples the second strobe.
- R9: `disp_req` stays 1 until `disp_ack` is sampled high, and falls at that edge.
- R10: `sleep_req` is ignored while a dispatch is deferred (still counting retires) or pending (`disp_req` high). `standby` stays 0.
- R11: A wake that does not lead to dispatch returns to the running state. `disp_req` stays 0 whatever `retire` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter standby |
| mreq | input | 64 | Maskable request flags, eight groups of eight |
| men | input | 64 | Per-flag enables matching `mreq` |
| nmi_req | input | 1 | Non-maskable request |
| nest_lvl | input | 2 | Current interrupt nesting level |
| mie | input | 1 | Global maskable interrupt enable |
| retire | input | 1 | One instruction completed this cycle |
| disp_ack | input | 1 | Processor has taken the dispatch |
| standby | output | 1 | Standby active (clock-stop request) |
| wake | output | 1 | One-cycle pulse on leaving standby |
| disp_req | output | 1 | Request to enter the interrupt handler |

## Verification
The bench wakes the block once through each of the 64 request/enable pairs. It also sweeps every combination of nesting level and global enable on both request paths, and on the two paths together. This catches an off-by-one group slice, a maskable threshold that lets level 2 through, and a priority that lets the maskable decision overrule the non-maskable one at level 2.

A request with its enable clear, and an enable with no request, must leave the block asleep. A design that ORs the vectors separately would wake in that case.

The retire gap is checked with idle cycles between the two strobes. A design that raises dispatch after one strobe, or counts from the wrong cycle, shows `disp_req` early. `sleep_req` is driven during both deferral and pending dispatch, so a design that honours it there would reassert `standby`.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int unsigned LVL_W        = 2;
    localparam int unsigned NMI_MAX_LVL  = 2;  // NMI dispatches at levels 0..2
    localparam int unsigned MASK_MAX_LVL = 1;  // maskable dispatches at 0..1
    localparam int unsigned RETIRE_GAP   = 2;  // instructions before dispatch

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_DEFER = 2'd2,
        ST_PEND  = 2'd3
    } stb_state_e;

    typedef struct packed {
        stb_state_e state;
        logic       standby;
        logic       wake;
        logic       disp_req;
    } stb_regs_t;

endpackage

// File: rtl/stb_wake_detect.sv
module stb_wake_detect #(
    parameter int unsigned GROUPS  = 8,
    parameter int unsigned GROUP_W = 8,
    localparam int unsigned VEC_W  = GROUPS * GROUP_W
) (
    input  logic [VEC_W-1:0] req,
    input  logic [VEC_W-1:0] en,
    output logic             hit
);

    logic [GROUPS-1:0] grp_hit;

    // Each group reduces its own request/enable pairs; groups are then ORed.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_hit[g] = |(req[g*GROUP_W +: GROUP_W] & en[g*GROUP_W +: GROUP_W]);
    end

    assign hit = |grp_hit;

endmodule

// File: rtl/stb_dispatch_policy.sv
module stb_dispatch_policy
    import stb_pkg::*;
(
    input  logic             nmi_hit,
    input  logic             mask_hit,
    input  logic [LVL_W-1:0] lvl,
    input  logic             mie,
    output logic             take
);

    logic nmi_ok;
    logic mask_ok;

    always_comb begin
        nmi_ok  = (int'(lvl) <= NMI_MAX_LVL);
        mask_ok = mie && (int'(lvl) <= MASK_MAX_LVL);
        // Non-maskable decision wins whenever its request is present.
        if (nmi_hit) begin
            take = nmi_ok;
        end else begin
            take = mask_hit && mask_ok;
        end
    end

endmodule

// File: rtl/stb_retire_count.sv
module stb_retire_count #(
    parameter int unsigned GAP = 2,
    localparam int unsigned CW = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        done  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            if (cnt_q == CW'(GAP - 1)) begin
                done  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(GAP));

endmodule

// File: rtl/stb_wake_gate.sv
module stb_wake_gate
    import stb_pkg::*;
#(
    parameter int unsigned GROUPS  = 8,
    parameter int unsigned GROUP_W = 8,
    localparam int unsigned VEC_W  = GROUPS * GROUP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic [VEC_W-1:0] mreq,
    input  logic [VEC_W-1:0] men,
    input  logic             nmi_req,
    input  logic [LVL_W-1:0] nest_lvl,
    input  logic             mie,
    input  logic             retire,
    input  logic             disp_ack,
    output logic             standby,
    output logic             wake,
    output logic             disp_req
);

    stb_regs_t r_d, r_q;
    logic      mask_hit;
    logic      take;
    logic      gap_clr;
    logic      gap_inc;
    logic      gap_done;
    logic      any_hit;

    stb_wake_detect #(
        .GROUPS  (GROUPS),
        .GROUP_W (GROUP_W)
    ) i_detect (
        .req (mreq),
        .en  (men),
        .hit (mask_hit)
    );

    stb_dispatch_policy i_policy (
        .nmi_hit  (nmi_req),
        .mask_hit (mask_hit),
        .lvl      (nest_lvl),
        .mie      (mie),
        .take     (take)
    );

    stb_retire_count #(
        .GAP (RETIRE_GAP)
    ) i_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gap_clr),
        .inc   (gap_inc),
        .done  (gap_done)
    );

    assign any_hit = nmi_req || mask_hit;

    always_comb begin
        r_d          = r_q;
        r_d.wake     = 1'b0;
        gap_clr      = 1'b0;
        gap_inc      = 1'b0;
        unique case (r_q.state)
            ST_RUN: begin
                if (sleep_req) begin
                    r_d.state   = ST_SLEEP;
                    r_d.standby = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (any_hit) begin
                    r_d.standby = 1'b0;
                    r_d.wake    = 1'b1;
                    gap_clr     = 1'b1;
                    r_d.state   = take ? ST_DEFER : ST_RUN;
                end
            end
            ST_DEFER: begin
                gap_inc = retire;
                if (gap_done) begin
                    r_d.state    = ST_PEND;
                    r_d.disp_req = 1'b1;
                end
            end
            ST_PEND: begin
                if (disp_ack) begin
                    r_d.state    = ST_RUN;
                    r_d.disp_req = 1'b0;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_RUN;
            r_q.standby  <= 1'b0;
            r_q.wake     <= 1'b0;
            r_q.disp_req <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign standby  = r_q.standby;
    assign wake     = r_q.wake;
    assign disp_req = r_q.disp_req;

    a_r4_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    a_r4_standby_drops: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (!standby && $past(standby)));

    a_r3_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !nmi_req && !mask_hit) |=> (standby && !wake));

    a_r9_hold_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_req && !disp_ack) |=> disp_req);

    a_r10_no_sleep_pending: assert property (@(posedge clk) disable iff (!rst_n)
        disp_req |-> !standby);

    a_r8_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_req) |-> $past(retire));

endmodule

// File: tb/test_stb_wake_gate.sv
module test_stb_wake_gate;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_W      = 64;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sleep_req;
    logic [VEC_W-1:0] mreq;
    logic [VEC_W-1:0] men;
    logic             nmi_req;
    logic [1:0]       nest_lvl;
    logic             mie;
    logic             retire;
    logic             disp_ack;
    logic             standby;
    logic             wake;
    logic             disp_req;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stb_wake_gate i_stb_wake_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .mreq      (mreq),
        .men       (men),
        .nmi_req   (nmi_req),
        .nest_lvl  (nest_lvl),
        .mie       (mie),
        .retire    (retire),
        .disp_ack  (disp_ack),
        .standby   (standby),
        .wake      (wake),
        .disp_req  (disp_req)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // R2: enter standby from the running state
    task automatic do_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(standby, 1'b1, "R2 standby after sleep_req");
    endtask

    task automatic wake_case(input logic nmi, input logic [VEC_W-1:0] rq,
                             input logic [VEC_W-1:0] en, input logic [1:0] lvl,
                             input logic gie, input logic exp_disp, input string tag);
        do_sleep();
        nmi_req  = nmi;
        mreq     = rq;
        men      = en;
        nest_lvl = lvl;
        mie      = gie;
        @(negedge clk);
        chk(wake, 1'b1, {"R4 wake pulse ", tag});
        chk(standby, 1'b0, {"R4 standby cleared ", tag});
        nmi_req = 1'b0;
        mreq    = '0;
        men     = '0;
        retire  = 1'b1;            // first strobe, counted in wake cycle
        @(negedge clk);
        retire = 1'b0;
        chk(wake, 1'b0, {"R4 wake single cycle ", tag});
        chk(disp_req, 1'b0, {"R8 no dispatch after one retire ", tag});
        if (exp_disp) sleep_req = 1'b1;   // R10 during deferral
        @(negedge clk);
        sleep_req = 1'b0;
        chk(disp_req, 1'b0, {"R8 still waiting ", tag});
        chk(standby, 1'b0, {"R10 R11 no standby ", tag});
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        chk(disp_req, exp_disp, {"R5 R6 R7 dispatch decision ", tag});
        if (exp_disp) begin
            sleep_req = 1'b1;
            @(negedge clk);
            @(negedge clk);
            sleep_req = 1'b0;
            chk(disp_req, 1'b1, {"R9 held without ack ", tag});
            chk(standby, 1'b0, {"R10 sleep ignored while pending ", tag});
            disp_ack = 1'b1;
            @(negedge clk);
            disp_ack = 1'b0;
            chk(disp_req, 1'b0, {"R9 cleared by ack ", tag});
        end else begin
            retire = 1'b1;
            @(negedge clk);
            @(negedge clk);
            retire = 1'b0;
            chk(disp_req, 1'b0, {"R11 no dispatch on resume ", tag});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        sleep_req = 1'b0;
        mreq      = '0;
        men       = '0;
        nmi_req   = 1'b0;
        nest_lvl  = 2'd0;
        mie       = 1'b0;
        retire    = 1'b0;
        disp_ack  = 1'b0;
        repeat (3) @(negedge clk);
        chk(standby, 1'b0, "R1 standby in reset");
        chk(wake, 1'b0, "R1 wake in reset");
        chk(disp_req, 1'b0, "R1 disp_req in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(standby, 1'b0, "R1 standby after reset");
        chk(disp_req, 1'b0, "R1 disp_req after reset");

        // R3: non-qualifying flags leave the block asleep
        do_sleep();
        for (int k = 0; k < 8; k++) begin
            nest_lvl = 2'(k % 4);
            mie      = k[2];
            unique case (k % 3)
                0: begin mreq = '1; men = '0; end
                1: begin mreq = '0; men = '1; end
                default: begin mreq = 64'd1 << 37; men = ~(64'd1 << 37); end
            endcase
            @(negedge clk);
            chk(standby, 1'b1, "R3 stays asleep");
            chk(wake, 1'b0, "R3 no wake");
        end
        mreq = '0;
        men  = '0;
        // wake it with one qualifying pair, then resume
        nest_lvl = 2'd3;
        mie      = 1'b1;
        mreq     = 64'd1 << 37;
        men      = 64'd1 << 37;
        @(negedge clk);
        chk(wake, 1'b1, "R3 R4 wake once qualified");
        mreq = '0;
        men  = '0;
        @(negedge clk);

        // R4 R6: each of the 64 pairs, levels and mie swept arithmetically
        for (int i = 0; i < VEC_W; i++) begin
            logic [1:0] l;
            logic       g;
            l = 2'(i % 4);
            g = 1'((i / 4) % 2);
            wake_case(1'b0, 64'd1 << i, (64'd1 << i) | (64'd1 << ((i + 9) % 64)),
                      l, g, g && (l <= 2'd1), "R6 maskable");
        end

        // R5: non-maskable over all levels and mie
        for (int k = 0; k < 8; k++) begin
            logic [1:0] l;
            l = 2'(k % 4);
            wake_case(1'b1, '0, '0, l, 1'(k / 4), l <= 2'd2, "R5 nmi");
        end

        // R7: both paths together; non-maskable decision rules
        for (int k = 0; k < 8; k++) begin
            logic [1:0] l;
            l = 2'(k % 4);
            wake_case(1'b1, 64'd1 << (k * 8), '1, l, 1'(k / 4), l <= 2'd2, "R7 both");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule